// File: doc/BRIEF.md
# Serial Command Decoder for a Single-Wiper Digital Potentiometer

This block is the serial slave front end of a digital potentiometer with one wiper. A host selects it by pulling the chip select low. The host then clocks in an identification byte, an instruction byte and, for some commands, a data byte. The block checks that the frame is addressed to it, decodes the command and issues single-cycle strobes. Those strobes go to a wiper position register and a bank of sixteen byte registers, both held in neighbouring blocks. For read commands it returns one byte on the serial output.

The serial clock, data, select and pause inputs are brought into the system clock domain through two-stage synchronizers, and their edges are found there. Writes and transfers take effect only when the select line rises at the end of a frame that was long enough. A truncated frame therefore leaves every register alone. The increment/decrement command has no fixed length. It emits one wiper step for each serial clock pulse until the select line rises.

Top module: `spi_pot_decoder`

## Requirements
- R1: After reset, no frame is decoded until the decoder has seen chip select high and then low. A select that is held low through reset produces no strobe and keeps `so_oe` low.
- R2: The first byte, sent MSB first, must be 0101 in bits 7:4, 00 in bits 3:2 and the value of `addr_pins` in bits 1:0. On any mismatch the frame produces no strobe and `so_d` stays 0.
- R3: The second byte carries the opcode in bits 7:4, the register index in bits 3:2 and the bank in bits 1:0. `reg_addr` presents {bank, index}.
- R4: Opcode 1010 (load wiper) produces one `wiper_load` pulse when select rises after at least 24 bits, with `wdata` equal to the third byte.
- R5: Opcode 1100 (write register) produces one `reg_write` pulse when select rises after at least 24 bits, with `wdata` equal to the third byte and `reg_addr` from the second byte.
- R6: Opcode 1101 (register to wiper) and opcode 1110 (wiper to register) produce one `xfer_to_wiper` or `xfer_to_reg` pulse when select rises after at least 16 bits. This happens only when the bank field is 00; any other bank produces no strobe.
- R7: Opcodes 1001 (wiper position), 1011 (register at `reg_addr`) and 0101 (status, returned as seven zeros followed by `write_busy`) return a byte on `so_d`, MSB first. The MSB appears after the falling serial clock edge that ends bit 16, and the output moves one bit per later falling edge.
- R8: Opcode 0010 puts the decoder in stepping mode. Every rising serial clock edge after the instruction byte produces one `wiper_up` pulse if SI is high, or one `wiper_down` pulse if SI is low, until select rises. No step is produced during the first 16 bits.
- R9: A frame ended by select before its last bit produces no strobe. Bits beyond the 24th are ignored, so `wdata` holds bits 17 to 24.
- R10: `so_oe` is high only while the decoder is selected and not paused, and it is low while select is high.
- R11: Pulling the pause input low while SCK is low freezes the frame and drops `so_oe`, and SCK edges during the pause are ignored. Raising the pause input while SCK is low resumes the frame where it stopped.
- R12: Strobes last one clock cycle, at most one is active at a time, and write or transfer strobes appear only after select has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from host |
| si | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, active low |
| addr_pins | input | 2 | Strapped slave address |
| wiper_pos | input | 8 | Current wiper position from the wiper register |
| reg_rdata | input | 8 | Byte of the register bank at `reg_addr` |
| write_busy | input | 1 | Nonvolatile write in progress |
| so_d | output | 1 | Serial read data |
| so_oe | output | 1 | Output enable for the serial data pad |
| wiper_load | output | 1 | Load `wdata` into the wiper |
| wiper_up | output | 1 | Step wiper one tap toward the high end |
| wiper_down | output | 1 | Step wiper one tap toward the low end |
| xfer_to_wiper | output | 1 | Copy register `reg_addr` into the wiper |
| xfer_to_reg | output | 1 | Copy the wiper into register `reg_addr` |
| reg_write | output | 1 | Write `wdata` into register `reg_addr` |
| reg_addr | output | 4 | Register address {bank, index} |
| wdata | output | 8 | Data byte of the last write frame |

## Verification
The hardest states to reach are a pause in the middle of a read and a select that is already low when reset ends. Both depend on the order in which pins move relative to SCK, not only on byte values. The bench drives a pause after a few data bits of a read and of a write, toggles SCK with junk on SI while paused, and then resumes. It then checks that the returned byte and the written byte are intact. For the reset case it holds select low through reset and clocks a whole valid write, which must produce no strobe. A table of frames covers the opcodes, wrong addresses, the bank restriction on transfers, truncation and over-long frames.

// File: rtl/spi_pot_decoder.sv
module spi_pot_decoder #(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       hold_n,
  input  logic [1:0] addr_pins,
  input  logic [7:0] wiper_pos,
  input  logic [7:0] reg_rdata,
  input  logic       write_busy,
  output logic       so_d,
  output logic       so_oe,
  output logic       wiper_load,
  output logic       wiper_up,
  output logic       wiper_down,
  output logic       xfer_to_wiper,
  output logic       xfer_to_reg,
  output logic       reg_write,
  output logic [3:0] reg_addr,
  output logic [7:0] wdata
);

  localparam logic [4:0] ID_LAST  = 5'd7;
  localparam logic [4:0] INS_LAST = 5'd15;
  localparam logic [4:0] DAT_LAST = 5'd23;
  localparam logic [4:0] LEN2     = 5'd16;
  localparam logic [4:0] LEN3     = 5'd24;

  localparam logic [3:0] OP_RD_WIPER = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER = 4'b1010;
  localparam logic [3:0] OP_RD_REG   = 4'b1011;
  localparam logic [3:0] OP_WR_REG   = 4'b1100;
  localparam logic [3:0] OP_REG2WIP  = 4'b1101;
  localparam logic [3:0] OP_WIP2REG  = 4'b1110;
  localparam logic [3:0] OP_STEP     = 4'b0010;
  localparam logic [3:0] OP_STATUS   = 4'b0101;

  logic [3:0] in_m, in_s;
  logic       sck_d, cs_d, sel, paused;
  logic [4:0] cnt;
  logic [6:0] sh;
  logic       id_ok;
  logic [7:0] ins, dat, tx;
  logic [7:0] rd_val;
  logic       is_read;

  wire cs_s   = in_s[3];
  wire sck_s  = in_s[2];
  wire si_s   = in_s[1];
  wire hold_s = in_s[0];

  wire [7:0] nb       = {sh, si_s};
  wire [3:0] op       = ins[7:4];
  wire       bank0    = (ins[1:0] == 2'b00);
  wire       id_match = (nb[7:4] == DEV_TYPE) && (nb[3:2] == 2'b00) && (nb[1:0] == addr_pins);
  wire       cs_fall  = cs_d & ~cs_s;
  wire       cs_rise  = sel & cs_s & ~cs_d;
  wire       sck_rise = sel & ~paused & sck_s & ~sck_d;
  wire       sck_fall = sel & ~paused & ~sck_s & sck_d;
  wire       stepping = id_ok && (op == OP_STEP) && (cnt >= LEN2);

  assign reg_addr = {ins[1:0], ins[3:2]};
  assign wdata    = dat;
  assign so_d     = tx[7];
  assign so_oe    = sel & ~paused;

  always_comb begin
    is_read = 1'b1;
    rd_val  = 8'h00;
    case (op)
      OP_RD_WIPER: rd_val = wiper_pos;
      OP_RD_REG:   rd_val = reg_rdata;
      OP_STATUS:   rd_val = {7'b0, write_busy};
      default:     is_read = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_m          <= 4'b0001;
      in_s          <= 4'b0001;
      sck_d         <= 1'b0;
      cs_d          <= 1'b0;
      sel           <= 1'b0;
      paused        <= 1'b0;
      cnt           <= '0;
      sh            <= '0;
      id_ok         <= 1'b0;
      ins           <= '0;
      dat           <= '0;
      tx            <= '0;
      wiper_load    <= 1'b0;
      wiper_up      <= 1'b0;
      wiper_down    <= 1'b0;
      xfer_to_wiper <= 1'b0;
      xfer_to_reg   <= 1'b0;
      reg_write     <= 1'b0;
    end else begin
      in_m  <= {cs_n, sck, si, hold_n};
      in_s  <= in_m;
      sck_d <= sck_s;
      cs_d  <= cs_s;

      wiper_load    <= 1'b0;
      wiper_up      <= 1'b0;
      wiper_down    <= 1'b0;
      xfer_to_wiper <= 1'b0;
      xfer_to_reg   <= 1'b0;
      reg_write     <= 1'b0;

      if (cs_s) begin
        sel    <= 1'b0;
        paused <= 1'b0;
      end else begin
        if (cs_d) sel <= 1'b1;
        if (!sck_s) paused <= ~hold_s;
      end

      if (cs_fall) begin
        cnt   <= '0;
        sh    <= '0;
        id_ok <= 1'b0;
        ins   <= '0;
        dat   <= '0;
        tx    <= '0;
      end else if (sck_rise) begin
        sh <= nb[6:0];
        if (cnt != LEN3) cnt <= cnt + 5'd1;
        if (cnt == ID_LAST)  id_ok <= id_match;
        if (cnt == INS_LAST) ins   <= nb;
        if (cnt == DAT_LAST) dat   <= nb;
        if (stepping) begin
          wiper_up   <= si_s;
          wiper_down <= ~si_s;
        end
      end else if (sck_fall) begin
        if (cnt == LEN2 && id_ok && is_read) tx <= rd_val;
        else if (cnt > LEN2)                 tx <= {tx[6:0], 1'b0};
      end

      if (cs_rise && id_ok) begin
        wiper_load    <= (op == OP_WR_WIPER) && (cnt == LEN3);
        reg_write     <= (op == OP_WR_REG)   && (cnt == LEN3);
        xfer_to_wiper <= (op == OP_REG2WIP)  && (cnt >= LEN2) && bank0;
        xfer_to_reg   <= (op == OP_WIP2REG)  && (cnt >= LEN2) && bank0;
      end
    end
  end

endmodule

// File: rtl/spi_pot_decoder_chk.sv
module spi_pot_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic so_oe,
  input logic wiper_load,
  input logic wiper_up,
  input logic wiper_down,
  input logic xfer_to_wiper,
  input logic xfer_to_reg,
  input logic reg_write
);

  wire commit = wiper_load | reg_write | xfer_to_wiper | xfer_to_reg;

  a_r10_oe_off_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 3) |-> !so_oe);

  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wiper_load, wiper_up, wiper_down, xfer_to_wiper, xfer_to_reg, reg_write}));

  a_r12_commit_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(cs_n, 3));

  a_r4_load_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wiper_load |=> !wiper_load);

  a_r5_write_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_write |=> !reg_write);

  a_r8_step_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_up | wiper_down) |-> !$past(cs_n, 4));

  a_r8_step_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper_up | wiper_down) |=> !(wiper_up | wiper_down));

endmodule

bind spi_pot_decoder spi_pot_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe),
  .wiper_load(wiper_load), .wiper_up(wiper_up), .wiper_down(wiper_down),
  .xfer_to_wiper(xfer_to_wiper), .xfer_to_reg(xfer_to_reg), .reg_write(reg_write)
);

// File: tb/tb_spi_pot_decoder.sv
`timescale 1ns/1ps
module tb_spi_pot_decoder;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, sck, si, hold_n;
  logic [1:0] addr_pins = 2'b10;
  logic [7:0] wiper_pos = 8'hA5;
  logic       write_busy = 1'b1;
  logic [7:0] reg_rdata;
  logic       so_d, so_oe, wiper_load, wiper_up, wiper_down, xfer_to_wiper, xfer_to_reg, reg_write;
  logic [3:0] reg_addr;
  logic [7:0] wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  assign reg_rdata = {4'hC, reg_addr};

  spi_pot_decoder dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .addr_pins(addr_pins), .wiper_pos(wiper_pos), .reg_rdata(reg_rdata),
    .write_busy(write_busy), .so_d(so_d), .so_oe(so_oe), .wiper_load(wiper_load),
    .wiper_up(wiper_up), .wiper_down(wiper_down), .xfer_to_wiper(xfer_to_wiper),
    .xfer_to_reg(xfer_to_reg), .reg_write(reg_write), .reg_addr(reg_addr), .wdata(wdata)
  );

  logic       clr = 1'b0;
  logic [3:0] c_load, c_rw, c_x2w, c_x2r, c_up, c_dn;
  logic [3:0] s_addr;
  logic [7:0] s_data;

  always_ff @(posedge clk) begin
    if (clr) begin
      c_load <= '0; c_rw <= '0; c_x2w <= '0; c_x2r <= '0; c_up <= '0; c_dn <= '0;
      s_addr <= '0; s_data <= '0;
    end else begin
      if (wiper_load) begin c_load <= c_load + 4'd1; s_data <= wdata; end
      if (reg_write)  begin c_rw <= c_rw + 4'd1; s_data <= wdata; s_addr <= reg_addr; end
      if (xfer_to_wiper) begin c_x2w <= c_x2w + 4'd1; s_addr <= reg_addr; end
      if (xfer_to_reg)   begin c_x2r <= c_x2r + 4'd1; s_addr <= reg_addr; end
      if (wiper_up)   c_up <= c_up + 4'd1;
      if (wiper_down) c_dn <= c_dn + 4'd1;
    end
  end

  wire [23:0] counts = {c_load, c_rw, c_x2w, c_x2r, c_up, c_dn};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic clear();
    clr = 1'b1;
    @(posedge clk);
    #1;
    clr = 1'b0;
  endtask

  task automatic pause_now();
    hold_n = 1'b0;
    half();
    check(so_oe == 1'b0, "R11 oe during pause", {31'b0, so_oe}, 0);
    for (int k = 0; k < 3; k++) begin
      si = ~si; sck = 1'b1; half(); sck = 1'b0; half();
    end
    hold_n = 1'b1;
    half();
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input int pause_at, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (i == pause_at) pause_now();
      si = w[31-i];
      half();
      if (i >= 16 && i < 24) rx = {rx[6:0], so_d};
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic end_frame();
    half();
    cs_n = 1'b1;
    repeat (12) @(posedge clk);
    #1;
  endtask

  localparam int NV = 16;
  localparam logic [47:0] VEC [NV] = '{
    {8'h52, 8'hA0, 8'h3C, 8'd24, 8'd1, 8'h3C},
    {8'h52, 8'hC6, 8'h77, 8'd24, 8'd2, 8'h77},
    {8'h52, 8'hD8, 8'h00, 8'd16, 8'd3, 8'h00},
    {8'h52, 8'hEC, 8'h00, 8'd16, 8'd4, 8'h00},
    {8'h52, 8'hD1, 8'h00, 8'd16, 8'd0, 8'h00},
    {8'h52, 8'hE2, 8'h00, 8'd16, 8'd0, 8'h00},
    {8'h52, 8'h90, 8'h00, 8'd24, 8'd5, 8'hA5},
    {8'h52, 8'hB7, 8'h00, 8'd24, 8'd5, 8'hCD},
    {8'h52, 8'h50, 8'h00, 8'd24, 8'd5, 8'h01},
    {8'h51, 8'hA0, 8'h3C, 8'd24, 8'd0, 8'h00},
    {8'h72, 8'hA0, 8'h3C, 8'd24, 8'd0, 8'h00},
    {8'h56, 8'hA0, 8'h3C, 8'd24, 8'd0, 8'h00},
    {8'h51, 8'h90, 8'h00, 8'd24, 8'd5, 8'h00},
    {8'h52, 8'hA0, 8'h3C, 8'd20, 8'd0, 8'h00},
    {8'h52, 8'hD0, 8'h00, 8'd12, 8'd0, 8'h00},
    {8'h52, 8'hA0, 8'h3C, 8'd30, 8'd1, 8'h3C}
  };

  function automatic string req_of(input logic [7:0] kind);
    case (kind)
      8'd1: return "R4";
      8'd2: return "R5";
      8'd3, 8'd4: return "R6";
      8'd5: return "R7";
      default: return "R2/R9";
    endcase
  endfunction

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    clear();
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    half();
    check(so_oe == 1'b0 && so_d == 1'b0, "R10 reset outputs", {so_oe, so_d}, 0);
    check(counts == 24'h0, "R12 reset strobes", counts, 0);

    // R1: select low through reset, valid write must be ignored
    send_word({8'h52, 8'hA0, 8'h3C, 8'h00}, 24, -1, rx);
    check(so_oe == 1'b0, "R1 oe without select edge", {31'b0, so_oe}, 0);
    end_frame();
    check(counts == 24'h0, "R1 no strobe without select edge", counts, 0);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] id, ins, dat, nb, kind, exp;
      logic [23:0] ec;
      {id, ins, dat, nb, kind, exp} = VEC[v];
      clear();
      cs_n = 1'b0;
      half();
      send_word({id, ins, dat, 8'hFF}, int'(nb), -1, rx);
      end_frame();
      ec = {3'b0, kind == 8'd1, 3'b0, kind == 8'd2, 3'b0, kind == 8'd3, 3'b0, kind == 8'd4, 8'h00};
      check(counts == ec, {req_of(kind), " strobe counts"}, counts, ec);
      if (kind == 8'd1 || kind == 8'd2)
        check(s_data == exp, {req_of(kind), " wdata"}, s_data, exp);
      if (kind >= 8'd2 && kind <= 8'd4)
        check(s_addr == {ins[1:0], ins[3:2]}, "R3 reg_addr", s_addr, {ins[1:0], ins[3:2]});
      if (kind == 8'd5)
        check(rx == exp, {req_of(kind), " read byte"}, rx, exp);
    end

    // R8: stepping
    clear();
    cs_n = 1'b0;
    half();
    send_word({8'h52, 8'h20, 16'h0}, 16, -1, rx);
    half();
    check(counts == 24'h0, "R8 no step in header", counts, 0);
    send_word({5'b11010, 27'h0}, 5, -1, rx);
    check(so_oe == 1'b1, "R10 oe while selected", {31'b0, so_oe}, 1);
    end_frame();
    check(c_up == 4'd3 && c_dn == 4'd2, "R8 step counts", {c_up, c_dn}, 8'h32);
    check(so_oe == 1'b0, "R10 oe after deselect", {31'b0, so_oe}, 0);
    si = 1'b1;
    for (int k = 0; k < 3; k++) begin sck = 1'b1; half(); sck = 1'b0; half(); end
    check(c_up == 4'd3, "R8 no step after select rises", c_up, 3);

    // R11: pause in the middle of a read
    clear();
    cs_n = 1'b0;
    half();
    send_word({8'h52, 8'h90, 8'h00, 8'h00}, 24, 19, rx);
    end_frame();
    check(rx == 8'hA5, "R11 read across pause", rx, 8'hA5);

    // R11: pause in the middle of a write
    clear();
    cs_n = 1'b0;
    half();
    send_word({8'h52, 8'hA0, 8'h5A, 8'h00}, 24, 20, rx);
    end_frame();
    check(c_load == 4'd1 && s_data == 8'h5A, "R11 write across pause", {c_load, s_data}, 12'h15A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule